// File: doc/BRIEF.md
# Receive Drain Arbiter for Completion and Request Queues

This block chooses which of two receive queues is drained next toward the user side. One queue holds completions. The other holds posted and non-posted requests in the order they arrived. Each queue offers packets beat by beat over a valid/ready handshake with an end-of-packet marker. The arbiter merges both queues into a single downstream stream and adds a flag that names the source of each beat. A source is only chosen at a packet boundary. Once chosen, it keeps the grant until its end-of-packet beat is accepted.

In the default policy, completions are preferred. Requests win when one of three things holds: their queue level has reached a backlog threshold, a waiting non-posted request is about to be overtaken by too many completions, or there is no completion to send. While the backlog rule keeps requests flowing, completions get a turn after a bounded run of request packets, so that a finite completion buffer cannot overflow. A policy input selects a request-first mode. That mode is meant for links where only one posted header and one non-posted header can be outstanding. In it, any pending request packet is drained before completions.

Top module: `rx_drain_arb`

## Requirements
- R1: After reset no packet is in progress, all counters are zero, the completion queue (`outFromReq` = 0) is the selected source, and with both queues empty `outValid`, `cplReady` and `reqReady` are 0.
- R2: At most one of `cplReady`/`reqReady` is high in a cycle. `outValid`, `outData` and `outEop` mirror the queue that holds the grant, and that queue's ready equals `outReady`.
- R3: The source changes only at a packet boundary. After a non-final beat is accepted, the same queue keeps the grant until its `outEop` beat is accepted.
- R4: While `npWaiting` is high, at most WINDOW-1 completion packets end downstream before a request packet is granted. The count clears in any cycle where `npWaiting` is low. At the limit, completions are not granted and a valid request queue is.
- R5: In default mode (`preferReq` = 0), at a boundary with `reqLevel` at or above the effective threshold, the request queue is granted even if completions are valid (unless R4 or R6 decides).
- R6: In default mode, after REQ_BURST request packets in a row, a valid completion is granted at the next boundary (unless R4 blocks completions). The run count clears when a completion packet ends.
- R7: With `preferReq` = 1, the request queue is granted at every boundary where `reqValid` is high. Completions are granted only when no request is valid.
- R8: A `backlogThresh` of 0 selects an effective threshold of REQ_DEPTH/2. Any other value is used as is.
- R9: In default mode, below the threshold with no limit active, a valid completion wins over a valid request. A lone valid request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cplValid | input | 1 | Completion queue has a beat |
| cplData | input | DATA_W | Completion beat data |
| cplEop | input | 1 | Completion beat is the last of its packet |
| cplReady | output | 1 | Completion beat is taken |
| reqValid | input | 1 | Request queue has a beat |
| reqData | input | DATA_W | Request beat data |
| reqEop | input | 1 | Request beat is the last of its packet |
| reqReady | output | 1 | Request beat is taken |
| npWaiting | input | 1 | A non-posted request is held in the request queue |
| reqLevel | input | LEVEL_W | Packets held in the request queue |
| backlogThresh | input | LEVEL_W | Backlog threshold, 0 selects REQ_DEPTH/2 |
| preferReq | input | 1 | 1 selects the request-first policy |
| outValid | output | 1 | Downstream beat valid |
| outData | output | DATA_W | Downstream beat data |
| outEop | output | 1 | Downstream beat ends a packet |
| outReady | input | 1 | Downstream accepts the beat |
| outFromReq | output | 1 | Source of the current grant: 1 request, 0 completion |

## Verification
A behavioural model mirrors every cycle. Completion-only traffic with multi-beat packets and a stalling `outReady` shows whether grants are held across a packet. A long run of single-beat completions behind one non-posted request separates the overtaking limit from the default completion preference. Request floods at low, zero and high thresholds show the backlog switch, the half-depth default and the bounded request run apart. A request-first phase and a long random mix with changing policy and threshold then test how the rules interact under back-pressure.

// File: rtl/rx_drain_pkg.sv
package rx_drain_pkg;

  typedef enum logic {
    SRC_CPL = 1'b0,
    SRC_REQ = 1'b1
  } src_e;

  // control -> datapath
  typedef struct packed {
    logic grantCpl;
    logic grantReq;
  } grant_t;

  // datapath -> control
  typedef struct packed {
    logic beat;
    logic pktEnd;
  } accept_t;

endpackage

// File: rtl/rx_drain_ctrl.sv
module rx_drain_ctrl
  import rx_drain_pkg::*;
#(
  parameter int LEVEL_W   = 6,
  parameter int REQ_DEPTH = 32,
  parameter int WINDOW    = 64,
  parameter int REQ_BURST = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cplValid,
  input  logic               reqValid,
  input  logic               npWaiting,
  input  logic               preferReq,
  input  logic [LEVEL_W-1:0] reqLevel,
  input  logic [LEVEL_W-1:0] backlogThresh,
  input  accept_t            accept,
  output grant_t             grant,
  output src_e               curSrc
);

  localparam int OV_LIMIT      = WINDOW - 1;
  localparam int OV_W          = $clog2(WINDOW + 1);
  localparam int RUN_W         = $clog2(REQ_BURST + 1);
  localparam int DEFAULT_THRESH = REQ_DEPTH / 2;

  logic             inPkt;
  src_e             lockSrc;
  logic [OV_W-1:0]  ovCnt;
  logic [RUN_W-1:0] runCnt;

  logic [LEVEL_W-1:0] effThresh;
  logic cplBlocked, backlogHigh, burstDone;
  logic pickValid;
  src_e pickSrc;

  always_comb begin
    effThresh   = (backlogThresh == '0) ? LEVEL_W'(DEFAULT_THRESH) : backlogThresh;
    cplBlocked  = npWaiting && (ovCnt >= OV_W'(OV_LIMIT));
    backlogHigh = reqLevel >= effThresh;
    burstDone   = runCnt >= RUN_W'(REQ_BURST);
  end

  // boundary decision, priority ordered
  always_comb begin
    pickValid = 1'b0;
    pickSrc   = lockSrc;
    if (preferReq) begin
      if (reqValid) begin
        pickValid = 1'b1; pickSrc = SRC_REQ;
      end else if (cplValid && !cplBlocked) begin
        pickValid = 1'b1; pickSrc = SRC_CPL;
      end
    end else if (reqValid && cplBlocked) begin
      pickValid = 1'b1; pickSrc = SRC_REQ;
    end else if (cplValid && !cplBlocked && burstDone) begin
      pickValid = 1'b1; pickSrc = SRC_CPL;
    end else if (reqValid && backlogHigh) begin
      pickValid = 1'b1; pickSrc = SRC_REQ;
    end else if (cplValid && !cplBlocked) begin
      pickValid = 1'b1; pickSrc = SRC_CPL;
    end else if (reqValid) begin
      pickValid = 1'b1; pickSrc = SRC_REQ;
    end
  end

  always_comb begin
    curSrc = inPkt ? lockSrc : pickSrc;
    grant.grantCpl = (inPkt || pickValid) && (curSrc == SRC_CPL);
    grant.grantReq = (inPkt || pickValid) && (curSrc == SRC_REQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt   <= 1'b0;
      lockSrc <= SRC_CPL;
      ovCnt   <= '0;
      runCnt  <= '0;
    end else begin
      if (accept.beat) begin
        lockSrc <= curSrc;
        inPkt   <= !accept.pktEnd;
      end
      if (accept.pktEnd) begin
        if (curSrc == SRC_REQ) begin
          if (!burstDone) runCnt <= runCnt + 1'b1;
        end else begin
          runCnt <= '0;
        end
      end
      if (!npWaiting) begin
        ovCnt <= '0;
      end else if (accept.pktEnd && curSrc == SRC_CPL && ovCnt < OV_W'(OV_LIMIT)) begin
        ovCnt <= ovCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_drain_dp.sv
module rx_drain_dp
  import rx_drain_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  grant_t             grant,
  input  logic               cplValid,
  input  logic [DATA_W-1:0]  cplData,
  input  logic               cplEop,
  input  logic               reqValid,
  input  logic [DATA_W-1:0]  reqData,
  input  logic               reqEop,
  input  logic               outReady,
  output logic               cplReady,
  output logic               reqReady,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  output logic               outEop,
  output accept_t            accept
);

  always_comb begin
    cplReady = grant.grantCpl && outReady;
    reqReady = grant.grantReq && outReady;
    outValid = (grant.grantCpl && cplValid) || (grant.grantReq && reqValid);
    outData  = grant.grantReq ? reqData : cplData;
    outEop   = grant.grantReq ? reqEop  : cplEop;
    accept.beat   = outValid && outReady;
    accept.pktEnd = outValid && outReady && outEop;
  end

endmodule

// File: rtl/rx_drain_arb.sv
module rx_drain_arb
  import rx_drain_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int REQ_DEPTH = 32,
  parameter int LEVEL_W   = $clog2(REQ_DEPTH + 1),
  parameter int WINDOW    = 64,
  parameter int REQ_BURST = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cplValid,
  input  logic [DATA_W-1:0]  cplData,
  input  logic               cplEop,
  output logic               cplReady,
  input  logic               reqValid,
  input  logic [DATA_W-1:0]  reqData,
  input  logic               reqEop,
  output logic               reqReady,
  input  logic               npWaiting,
  input  logic [LEVEL_W-1:0] reqLevel,
  input  logic [LEVEL_W-1:0] backlogThresh,
  input  logic               preferReq,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  output logic               outEop,
  input  logic               outReady,
  output logic               outFromReq
);

  grant_t  grant;
  accept_t accept;
  src_e    curSrc;

  rx_drain_ctrl #(
    .LEVEL_W(LEVEL_W), .REQ_DEPTH(REQ_DEPTH), .WINDOW(WINDOW), .REQ_BURST(REQ_BURST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cplValid(cplValid), .reqValid(reqValid),
    .npWaiting(npWaiting), .preferReq(preferReq), .reqLevel(reqLevel),
    .backlogThresh(backlogThresh), .accept(accept), .grant(grant), .curSrc(curSrc)
  );

  rx_drain_dp #(.DATA_W(DATA_W)) u_dp (
    .grant(grant), .cplValid(cplValid), .cplData(cplData), .cplEop(cplEop),
    .reqValid(reqValid), .reqData(reqData), .reqEop(reqEop), .outReady(outReady),
    .cplReady(cplReady), .reqReady(reqReady), .outValid(outValid),
    .outData(outData), .outEop(outEop), .accept(accept)
  );

  assign outFromReq = (curSrc == SRC_REQ);

endmodule

// File: rtl/rx_drain_arb_chk.sv
module rx_drain_arb_chk #(
  parameter int WINDOW = 64
) (
  input logic clk,
  input logic rstN,
  input logic cplReady,
  input logic reqValid,
  input logic reqReady,
  input logic npWaiting,
  input logic preferReq,
  input logic outValid,
  input logic outEop,
  input logic outReady,
  input logic outFromReq
);

  localparam int LIMIT = WINDOW - 1;
  localparam int OV_W  = $clog2(WINDOW + 1);

  logic            chkInPkt;
  logic [OV_W-1:0] chkOv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkInPkt <= 1'b0;
      chkOv    <= '0;
    end else begin
      if (outValid && outReady) chkInPkt <= !outEop;
      if (!npWaiting) chkOv <= '0;
      else if (outValid && outReady && outEop && !outFromReq && chkOv != '1)
        chkOv <= chkOv + 1'b1;
    end
  end

  a_r2_single_ready: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cplReady, reqReady}));

  a_r3_hold_source: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outEop) |=> (outFromReq == $past(outFromReq)));

  a_r4_window: assert property (@(posedge clk) disable iff (!rstN)
    chkOv <= OV_W'(LIMIT));

  a_r7_prefer_req: assert property (@(posedge clk) disable iff (!rstN)
    (preferReq && reqValid && !chkInPkt) |-> (outFromReq && (reqReady == outReady)));

endmodule

bind rx_drain_arb rx_drain_arb_chk #(.WINDOW(WINDOW)) u_chk (
  .clk(clk), .rstN(rstN), .cplReady(cplReady), .reqValid(reqValid),
  .reqReady(reqReady), .npWaiting(npWaiting), .preferReq(preferReq),
  .outValid(outValid), .outEop(outEop), .outReady(outReady), .outFromReq(outFromReq)
);

// File: tb/sim_rx_drain_arb.sv
module sim_rx_drain_arb;

  localparam int DATA_W    = 16;
  localparam int REQ_DEPTH = 32;
  localparam int LEVEL_W   = 6;
  localparam int WINDOW    = 8;
  localparam int REQ_BURST = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cplValid = 0, cplEop = 0, reqValid = 0, reqEop = 0;
  logic [DATA_W-1:0] cplData = '0, reqData = '0;
  logic npWaiting = 0, preferReq = 0, outReady = 0;
  logic [LEVEL_W-1:0] reqLevel = '0, backlogThresh = '0;
  logic cplReady, reqReady, outValid, outEop, outFromReq;
  logic [DATA_W-1:0] outData;

  always #5 clk = ~clk;

  rx_drain_arb #(
    .DATA_W(DATA_W), .REQ_DEPTH(REQ_DEPTH), .LEVEL_W(LEVEL_W),
    .WINDOW(WINDOW), .REQ_BURST(REQ_BURST)
  ) u0 (
    .clk(clk), .rstN(rstN), .cplValid(cplValid), .cplData(cplData), .cplEop(cplEop),
    .cplReady(cplReady), .reqValid(reqValid), .reqData(reqData), .reqEop(reqEop),
    .reqReady(reqReady), .npWaiting(npWaiting), .reqLevel(reqLevel),
    .backlogThresh(backlogThresh), .preferReq(preferReq), .outValid(outValid),
    .outData(outData), .outEop(outEop), .outReady(outReady), .outFromReq(outFromReq)
  );

  int nCompared = 0, nMismatched = 0;
  bit finished = 0;
  string tag = "R1";
  bit readyRand = 0;

  // bench packet queues
  int cLen[$], cId[$], rLen[$], rId[$];
  bit rNp[$];
  int cBeat = 0, rBeat = 0, nextId = 1;

  // reference model state
  bit mInPkt = 0;
  int mLock = 0, mOv = 0, mRun = 0;
  int obsOv = 0;

  function automatic bit anyNp();
    foreach (rNp[i]) if (rNp[i]) return 1;
    return 0;
  endfunction

  function automatic int pickSrc(bit cv, bit rv, bit np, bit pref, int lvl, int thr);
    int eff = (thr == 0) ? REQ_DEPTH / 2 : thr;
    bit blk = np && (mOv >= WINDOW - 1);
    if (pref) begin
      if (rv) return 1;
      if (cv && !blk) return 0;
      return -1;
    end
    if (rv && blk) return 1;
    if (cv && !blk && mRun >= REQ_BURST) return 0;
    if (rv && lvl >= eff) return 1;
    if (cv && !blk) return 0;
    if (rv) return 1;
    return -1;
  endfunction

  task automatic pushCpl(int len);
    cLen.push_back(len); cId.push_back(nextId); nextId = (nextId + 1) % 128;
  endtask

  task automatic pushReq(int len, bit np);
    rLen.push_back(len); rId.push_back(nextId + 128); rNp.push_back(np);
    nextId = (nextId + 1) % 128;
  endtask

  task automatic cycle();
    bit cv, rv, np, ce, re, ev, eeop, fire, cr, rr;
    int lvl, g, es;
    logic [DATA_W-1:0] cd, rd, ed;
    @(negedge clk);
    cv = cLen.size() > 0; rv = rLen.size() > 0; np = anyNp();
    lvl = (rLen.size() > 63) ? 63 : rLen.size();
    cd = '0; rd = '0; ce = 0; re = 0;
    if (cv) begin cd = {8'(cId[0]), 8'(cBeat)}; ce = (cBeat == cLen[0] - 1); end
    if (rv) begin rd = {8'(rId[0]), 8'(rBeat)}; re = (rBeat == rLen[0] - 1); end
    cplValid = cv; cplData = cd; cplEop = ce;
    reqValid = rv; reqData = rd; reqEop = re;
    npWaiting = np; reqLevel = LEVEL_W'(lvl);
    outReady = readyRand ? (($urandom % 10) < 7) : 1'b1;
    #1;
    g  = mInPkt ? mLock : pickSrc(cv, rv, np, preferReq, lvl, int'(backlogThresh));
    es = (g < 0) ? mLock : g;
    ev = (g == 0 && cv) || (g == 1 && rv);
    ed = (g == 1) ? rd : cd;
    eeop = (g == 1) ? re : ce;
    cr = (g == 0) && outReady;
    rr = (g == 1) && outReady;
    nCompared++;
    if (outValid !== ev || cplReady !== cr || reqReady !== rr || outFromReq !== es[0] ||
        (ev && (outData !== ed || outEop !== eeop))) begin
      nMismatched++;
      $display("FAIL %s: got v=%b d=%h e=%b src=%b cr=%b rr=%b, expected v=%b d=%h e=%b src=%0d cr=%b rr=%b",
               tag, outValid, outData, outEop, outFromReq, cplReady, reqReady,
               ev, ed, eeop, es, cr, rr);
    end
    // R4: overtaking count observed at the ports
    if (!np) obsOv = 0;
    else if (outValid && outReady && outEop && !outFromReq) begin
      obsOv++;
      nCompared++;
      if (obsOv > WINDOW - 1) begin
        nMismatched++;
        $display("FAIL R4: %0d completions passed a waiting request, expected at most %0d",
                 obsOv, WINDOW - 1);
      end
    end
    fire = ev && outReady;
    @(posedge clk); #1;
    if (fire) begin
      mLock = g; mInPkt = !eeop;
      if (eeop) mRun = (g == 1) ? ((mRun < REQ_BURST) ? mRun + 1 : mRun) : 0;
      if (g == 0) begin
        cBeat++;
        if (cBeat == cLen[0]) begin void'(cLen.pop_front()); void'(cId.pop_front()); cBeat = 0; end
      end else begin
        rBeat++;
        if (rBeat == rLen[0]) begin
          void'(rLen.pop_front()); void'(rId.pop_front()); void'(rNp.pop_front()); rBeat = 0;
        end
      end
    end
    if (!np) mOv = 0;
    else if (fire && eeop && g == 0) mOv++;
  endtask

  task automatic drain(int maxCycles);
    for (int n = 0; n < maxCycles; n++) begin
      if (cLen.size() == 0 && rLen.size() == 0 && !mInPkt) break;
      cycle();
    end
    cycle(); cycle();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nMismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    backlogThresh = 6'd20;

    tag = "R1";                        // reset state, idle queues
    repeat (3) cycle();

    tag = "R3"; readyRand = 1;         // multi-beat completions, stalls
    for (int i = 0; i < 6; i++) pushCpl(1 + i % 4);
    drain(200);

    tag = "R9"; readyRand = 0;         // completion preferred under threshold
    pushReq(2, 0);
    for (int i = 0; i < 3; i++) pushCpl(2);
    drain(100);

    tag = "R4";                        // overtaking window
    pushReq(2, 1);
    for (int i = 0; i < 12; i++) pushCpl(1);
    drain(100);

    tag = "R5"; backlogThresh = 6'd2;  // backlog switch
    for (int i = 0; i < 4; i++) pushReq(1, 0);
    for (int i = 0; i < 3; i++) pushCpl(1);
    drain(100);

    tag = "R6"; backlogThresh = 6'd1;  // bounded request run
    for (int i = 0; i < 8; i++) pushReq(2, 0);
    for (int i = 0; i < 5; i++) pushCpl(1);
    drain(200);

    tag = "R8"; backlogThresh = 6'd0;  // zero threshold means half depth
    for (int i = 0; i < 17; i++) pushReq(1, 0);
    for (int i = 0; i < 2; i++) pushCpl(1);
    drain(200);

    tag = "R7"; preferReq = 1; readyRand = 1; backlogThresh = 6'd20;
    for (int i = 0; i < 6; i++) pushCpl(2);
    for (int i = 0; i < 4; i++) pushReq(1 + i % 2, i[0]);
    drain(200);

    tag = "R2";                        // random mix
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) begin
        preferReq = $urandom % 3 == 0;
        backlogThresh = LEVEL_W'($urandom % 7);
      end
      if (cLen.size() < 30 && $urandom % 4 == 0) pushCpl(1 + $urandom % 4);
      if (rLen.size() < 30 && $urandom % 5 == 0) pushReq(1 + $urandom % 3, $urandom % 3 == 0);
      cycle();
    end
    drain(2000);
    finish();
  end

endmodule